// File: doc/BRIEF.md
# HDMI Sink Link Configuration Sequencer

This block sits on the source side of an HDMI link. It sets up the sink's TMDS transport through the sink's I2C control channel. A client raises one request at a time. The request either turns scrambling on or off, picks the high or the normal TMDS clock ratio, or asks whether the sink's scrambler is running. The block turns each request into a series of byte-level commands for an external I2C master. That master reports each command back with an ack flag and, for a read, a data byte.

A configuration change is a read-modify-write. The block first reads the sink's TMDS configuration byte at offset 0x20. It then changes only the target bit and writes the whole byte back. The high ratio divides the TMDS clock by 40 instead of 10 and is the setting used above a 340 MHz character clock. After a ratio write, the block waits a settle time of about 1.5 ms before it reports done. A status query reads offset 0x21 and returns bit 0.

Top module: `scdc_link_seq`

## Requirements
- R1: Every address byte sent is 0xA8 for a write phase or 0xA9 for a read phase. Both carry the 7-bit sink address 0x54.
- R2: A register read issues START, WRITE 0xA8, WRITE offset, RSTART, WRITE 0xA9, READ, STOP in that order. Command codes on cmd_o are START=0, WRITE=1, READ=2, RSTART=3, STOP=4. Exactly one command is outstanding, and cmd_valid_o is a one-cycle strobe.
- R3: A register write issues START, WRITE 0xA8, WRITE 0x20, WRITE data, STOP.
- R4: req_op_i=0 (scramble) reads offset 0x20 and writes back the same byte with bit 0 set to req_val_i. All other bits are kept.
- R5: req_op_i=1 (ratio) does the same on bit 1. req_val_i=1 selects the divide-by-40 ratio.
- R6: After a successful ratio write, done_o rises exactly CLK_HZ/2000*3 cycles later than it would after a scramble write.
- R7: req_op_i=2 or 3 (query) reads offset 0x21 and never writes. scr_o shows bit 0 of that byte with done_o. A failed read gives scr_o=0 and ok_o=0.
- R8: A NACK on any byte of the read phase makes the next command STOP. No write follows, and done_o comes with ok_o=0.
- R9: A NACK on any byte of the write phase makes the next command STOP, and done_o comes with ok_o=0.
- R10: err_o is set by any NACK. It stays set until the next request is accepted, and that acceptance clears it.
- R11: A request is accepted only while busy_o is low. busy_o rises in the next cycle. A request raised while busy is ignored. done_o is a one-cycle pulse, and busy_o falls with it.
- R12: After reset, busy_o, done_o, cmd_valid_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 scramble, 1 ratio, 2/3 query |
| req_val_i | input | 1 | New bit value for scramble/ratio |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Request succeeded, valid with done_o |
| scr_o | output | 1 | Scrambler active, valid with done_o |
| err_o | output | 1 | Latched NACK flag |
| cmd_valid_o | output | 1 | Command strobe to I2C master |
| cmd_o | output | 3 | Command code |
| cmd_data_o | output | 8 | Byte for WRITE commands |
| rsp_valid_i | input | 1 | Command completed |
| rsp_nack_i | input | 1 | Byte was not acknowledged |
| rsp_data_i | input | 8 | Byte returned by READ |

## Verification
A command strobe follows one cycle after the request is accepted, and one cycle after each response. The bench's I2C and sink model checks every strobe in the cycle it appears against a queue of expected commands, and answers two cycles later. done_o appears in the cycle after the STOP response for non-ratio requests. For a ratio request it appears CLK_HZ/2000*3 cycles later than that. The bench records the edge that sampled the STOP response and checks the measured gap against 0 or that count. err_o is sampled again after idle cycles and right after the next request is accepted.

// File: rtl/scdc_pkg.sv
package scdc_pkg;
  typedef enum logic [2:0] {
    CMD_START  = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_READ   = 3'd2,
    CMD_RSTART = 3'd3,
    CMD_STOP   = 3'd4
  } i2c_cmd_e;

  typedef enum logic [1:0] {
    OP_SCRAMBLE = 2'd0,
    OP_RATIO    = 2'd1,
    OP_QUERY    = 2'd2,
    OP_QUERY_B  = 2'd3
  } link_op_e;

  localparam logic [6:0] SINK_ADDR  = 7'h54;
  localparam logic [7:0] OFF_CFG    = 8'h20;
  localparam logic [7:0] OFF_STAT   = 8'h21;
  localparam int         BIT_SCR_EN = 0;
  localparam int         BIT_RATIO  = 1;
  localparam int         BIT_SCR_ON = 0;

  localparam int         STEP_W       = 4;
  localparam logic [3:0] STEP_RD_STOP = 4'd6;
  localparam logic [3:0] STEP_WR_GO   = 4'd7;
  localparam logic [3:0] STEP_WR_STOP = 4'd11;
endpackage

// File: rtl/scdc_step_dec.sv
module scdc_step_dec
  import scdc_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [7:0]        reg_off_i,
  input  logic [7:0]        wr_byte_i,
  output i2c_cmd_e          cmd_o,
  output logic [7:0]        data_o,
  output logic              chk_ack_o,
  output logic              rd_o,
  output logic              last_o
);
  localparam logic [7:0] ADDR_W = {SINK_ADDR, 1'b0};
  localparam logic [7:0] ADDR_R = {SINK_ADDR, 1'b1};

  always_comb begin
    cmd_o     = CMD_STOP;
    data_o    = 8'h00;
    chk_ack_o = 1'b0;
    rd_o      = 1'b0;
    last_o    = 1'b0;
    case (step_i)
      4'd0:  cmd_o = CMD_START;
      4'd1:  begin cmd_o = CMD_WRITE; data_o = ADDR_W;    chk_ack_o = 1'b1; end
      4'd2:  begin cmd_o = CMD_WRITE; data_o = reg_off_i; chk_ack_o = 1'b1; end
      4'd3:  cmd_o = CMD_RSTART;
      4'd4:  begin cmd_o = CMD_WRITE; data_o = ADDR_R;    chk_ack_o = 1'b1; end
      4'd5:  begin cmd_o = CMD_READ;  rd_o = 1'b1; end
      4'd7:  cmd_o = CMD_START;
      4'd8:  begin cmd_o = CMD_WRITE; data_o = ADDR_W;    chk_ack_o = 1'b1; end
      4'd9:  begin cmd_o = CMD_WRITE; data_o = OFF_CFG;   chk_ack_o = 1'b1; end
      4'd10: begin cmd_o = CMD_WRITE; data_o = wr_byte_i; chk_ack_o = 1'b1; end
      default: begin cmd_o = CMD_STOP; last_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/scdc_settle.sv
module scdc_settle #(
  parameter int unsigned CYCLES = 150000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned LOAD = (CYCLES < 1) ? 1 : CYCLES;
  localparam int unsigned CW   = $clog2(LOAD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (start_i)                   cnt_q <= CW'(LOAD);
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign expire_o = tick_i && (cnt_q == CW'(1));
endmodule

// File: rtl/scdc_link_seq.sv
module scdc_link_seq
  import scdc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] req_op_i,
  input  logic       req_val_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       ok_o,
  output logic       scr_o,
  output logic       err_o,
  output logic       cmd_valid_o,
  output logic [2:0] cmd_o,
  output logic [7:0] cmd_data_o,
  input  logic       rsp_valid_i,
  input  logic       rsp_nack_i,
  input  logic [7:0] rsp_data_i
);
  localparam int unsigned SETTLE_CYC = (CLK_HZ / 2000) * 3;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_SETTLE, S_FIN} st_e;

  st_e              state_q;
  link_op_e         op_q;
  logic             val_q, fail_q, ok_q, scr_q, err_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]       rbyte_q, reg_off, wr_byte;
  i2c_cmd_e         dec_cmd;
  logic [7:0]       dec_data;
  logic             dec_chk, dec_rd, dec_last;
  logic             tmr_start, tmr_expire, is_query;

  assign is_query = op_q[1];
  assign reg_off  = is_query ? OFF_STAT : OFF_CFG;

  always_comb begin
    wr_byte = rbyte_q;
    if (op_q == OP_RATIO) wr_byte[BIT_RATIO]  = val_q;
    else                  wr_byte[BIT_SCR_EN] = val_q;
  end

  scdc_step_dec u_dec (
    .step_i    (step_q),
    .reg_off_i (reg_off),
    .wr_byte_i (wr_byte),
    .cmd_o     (dec_cmd),
    .data_o    (dec_data),
    .chk_ack_o (dec_chk),
    .rd_o      (dec_rd),
    .last_o    (dec_last)
  );

  assign tmr_start = (state_q == S_WAIT) && rsp_valid_i && dec_last && !fail_q &&
                     (step_q == STEP_WR_STOP) && (op_q == OP_RATIO);

  scdc_settle #(.CYCLES(SETTLE_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .tick_i   (state_q == S_SETTLE),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_SCRAMBLE;
      val_q   <= 1'b0;
      fail_q  <= 1'b0;
      ok_q    <= 1'b0;
      scr_q   <= 1'b0;
      err_q   <= 1'b0;
      step_q  <= '0;
      rbyte_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_i) begin
          op_q    <= link_op_e'(req_op_i);
          val_q   <= req_val_i;
          fail_q  <= 1'b0;
          ok_q    <= 1'b0;
          scr_q   <= 1'b0;
          err_q   <= 1'b0;
          step_q  <= '0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (rsp_valid_i) begin
          state_q <= S_ISSUE;
          if (dec_chk && rsp_nack_i) begin
            // abandon transfer, close bus
            err_q  <= 1'b1;
            fail_q <= 1'b1;
            step_q <= (step_q < STEP_WR_GO) ? STEP_RD_STOP : STEP_WR_STOP;
          end else if (dec_rd) begin
            rbyte_q <= rsp_data_i;
            step_q  <= step_q + 4'd1;
          end else if (dec_last) begin
            if (fail_q) begin
              ok_q    <= 1'b0;
              scr_q   <= 1'b0;
              state_q <= S_FIN;
            end else if (step_q == STEP_RD_STOP) begin
              if (is_query) begin
                ok_q    <= 1'b1;
                scr_q   <= rbyte_q[BIT_SCR_ON];
                state_q <= S_FIN;
              end else begin
                step_q <= STEP_WR_GO;
              end
            end else if (op_q == OP_RATIO) begin
              state_q <= S_SETTLE;
            end else begin
              ok_q    <= 1'b1;
              state_q <= S_FIN;
            end
          end else begin
            step_q <= step_q + 4'd1;
          end
        end
        S_SETTLE: if (tmr_expire) begin
          ok_q    <= 1'b1;
          state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign ok_o        = ok_q;
  assign scr_o       = scr_q;
  assign err_o       = err_q;
  assign cmd_valid_o = (state_q == S_ISSUE);
  assign cmd_o       = dec_cmd;
  assign cmd_data_o  = dec_data;
endmodule

// File: rtl/scdc_link_seq_chk.sv
module scdc_link_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [1:0] req_op_i,
  input logic       req_val_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       ok_o,
  input logic       scr_o,
  input logic       err_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_o,
  input logic [7:0] cmd_data_o,
  input logic       rsp_valid_i,
  input logic       rsp_nack_i,
  input logic [7:0] rsp_data_i
);
  AST_CMD_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o); // R11
  AST_CMD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R11
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i |=> busy_o && !err_o); // R11
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !req_i |=> $stable(err_o)); // R10
  AST_ERR_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> !ok_o); // R10
  AST_ADDR_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o == 3'd1 && $past(cmd_valid_o, 2) && ($past(cmd_o, 2) == 3'd0 || $past(cmd_o, 2) == 3'd3)
    |-> cmd_data_o[7:1] == 7'h54); // R1
endmodule

bind scdc_link_seq scdc_link_seq_chk u_chk (.*);

// File: tb/sim_scdc_link_seq.sv
module sim_scdc_link_seq;
  localparam int unsigned CLK_HZ = 20_000;
  localparam int NSET = (CLK_HZ / 2000) * 3;
  localparam int LAT  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_val = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic busy, done, ok, scr, err, cmd_valid;
  logic [2:0] cmd;
  logic [7:0] cmd_data;
  logic rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0] rsp_data = 8'h00;

  always #5 clk = ~clk;

  scdc_link_seq #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_op_i(req_op), .req_val_i(req_val),
    .busy_o(busy), .done_o(done), .ok_o(ok), .scr_o(scr), .err_o(err),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_data_o(cmd_data),
    .rsp_valid_i(rsp_valid), .rsp_nack_i(rsp_nack), .rsp_data_i(rsp_data));

  int total = 0, bad = 0, cyc = 0;
  logic [10:0] exp_q[$];
  logic [7:0] sink_cfg = 8'hA4, sink_stat = 8'h00;
  int nack_at = -1, wr_idx = 0, byte_idx = 0, pend = 0, stop_edge = 0;
  logic rd_mode = 1'b0, pend_nack = 1'b0, pend_stop = 1'b0;
  logic [7:0] ptr = 8'h00, pend_data = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req_tag, input int act, input int expv, input string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, expv);
    end
  endtask

  // I2C master + sink model; compares every issued command on its clock
  always @(negedge clk) begin
    logic [10:0] e;
    rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rsp_valid = 1'b1; rsp_nack = pend_nack; rsp_data = pend_data;
        if (pend_stop) stop_edge = cyc + 1;
      end
    end
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) chk("R2", 32'(cmd), 99, "unexpected command");
      else begin
        e = exp_q.pop_front();
        chk("R2", 32'(cmd), 32'(e[10:8]), "command code");
        if (cmd == 3'd1) chk("R1/R3", 32'(cmd_data), 32'(e[7:0]), "write byte");
      end
      pend_nack = 1'b0; pend_data = 8'h00; pend_stop = (cmd == 3'd4); pend = LAT;
      case (cmd)
        3'd0, 3'd3: byte_idx = 0;
        3'd1: begin
          if (wr_idx == nack_at) pend_nack = 1'b1;
          else if (byte_idx == 0) begin rd_mode = cmd_data[0]; pend_nack = (cmd_data[7:1] != 7'h54); end
          else if (byte_idx == 1) ptr = cmd_data;
          else begin
            if (ptr == 8'h20) sink_cfg = cmd_data;
            ptr++;
          end
          wr_idx++; byte_idx++;
        end
        3'd2: pend_data = (ptr == 8'h20) ? sink_cfg : (ptr == 8'h21) ? sink_stat : 8'h00;
        default: ;
      endcase
    end
  end

  task automatic push(input logic [2:0] c, input logic [7:0] d);
    exp_q.push_back({c, d});
  endtask

  task automatic run_req(input logic [1:0] op, input logic v, input int nk,
                         input string tag, input int exp_ok, input int exp_scr, input int exp_gap);
    logic [7:0] off, nb;
    int n, gap;
    bit seen;
    off = op[1] ? 8'h21 : 8'h20;
    nb = sink_cfg;
    if (op == 2'd1) nb[1] = v; else nb[0] = v;
    nack_at = nk; wr_idx = 0;
    push(3'd0, 0); push(3'd1, 8'hA8);
    if (nk != 0) push(3'd1, off);
    if (nk > 1 || nk < 0) begin push(3'd3, 0); push(3'd1, 8'hA9); end
    if (nk > 2 || nk < 0) push(3'd2, 0);
    push(3'd4, 0);
    if (!op[1] && (nk > 2 || nk < 0)) begin
      push(3'd0, 0); push(3'd1, 8'hA8);
      if (nk != 3) push(3'd1, 8'h20);
      if (nk != 3 && nk != 4) push(3'd1, nb);
      push(3'd4, 0);
    end
    req = 1'b1; req_op = op; req_val = v;
    @(negedge clk); req = 1'b0;
    chk("R11", 32'(busy), 1, {tag, " busy after accept"});
    chk("R10", 32'(err), 0, {tag, " err cleared on accept"});
    seen = 0; gap = 0;
    for (n = 0; n < 2000 && !seen; n++) begin
      @(negedge clk);
      if (n == 3) begin req = 1'b1; req_op = 2'd2; end
      if (n == 4) req = 1'b0;
      if (done) begin seen = 1; gap = cyc - stop_edge; end
    end
    chk(tag, 32'(seen), 1, "done seen");
    chk(tag, 32'(ok), exp_ok, "ok");
    if (op[1]) chk("R7", 32'(scr), exp_scr, {tag, " scr"});
    chk("R6", gap, exp_gap, {tag, " settle gap"});
    chk(tag, exp_q.size(), 0, "commands left");
    @(negedge clk);
    chk("R11", 32'(busy), 0, {tag, " busy low after done"});
    chk("R11", 32'(done), 0, {tag, " done one cycle"});
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", 32'({busy, done, cmd_valid, err}), 0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", 32'({busy, done, cmd_valid, err}), 0, "after reset release");

    run_req(2'd0, 1'b1, -1, "R4 scr_on", 1, 0, 0);
    chk("R4", 32'(sink_cfg), 32'h0A5, "cfg after enable");
    run_req(2'd0, 1'b0, -1, "R4 scr_off", 1, 0, 0);
    chk("R4", 32'(sink_cfg), 32'h0A4, "cfg after disable");
    run_req(2'd1, 1'b1, -1, "R5 ratio_hi", 1, 0, NSET);
    chk("R5", 32'(sink_cfg), 32'h0A6, "cfg after high ratio");
    run_req(2'd1, 1'b0, -1, "R5 ratio_lo", 1, 0, NSET);
    chk("R5", 32'(sink_cfg), 32'h0A4, "cfg after normal ratio");

    sink_stat = 8'h01;
    run_req(2'd2, 1'b0, -1, "R7 query_on", 1, 1, 0);
    sink_stat = 8'hFE;
    run_req(2'd3, 1'b0, -1, "R7 query_off", 1, 0, 0);

    run_req(2'd0, 1'b1, 1, "R8 rd_nack", 0, 0, 0);
    chk("R8", 32'(sink_cfg), 32'h0A4, "cfg untouched");
    chk("R10", 32'(err), 1, "err set");
    repeat (5) @(negedge clk);
    chk("R10", 32'(err), 1, "err held while idle");

    run_req(2'd1, 1'b1, 5, "R9 wr_nack", 0, 0, 0);
    chk("R9", 32'(sink_cfg), 32'h0A4, "cfg not written");
    chk("R10", 32'(err), 1, "err after write nack");

    sink_stat = 8'h01;
    run_req(2'd2, 1'b0, 2, "R7 query_fail", 0, 0, 0);

    run_req(2'd0, 1'b1, -1, "R11 ignore_busy", 1, 0, 0);
    chk("R10", 32'(err), 0, "err clear after good request");
    repeat (20) @(negedge clk);
    chk("R11", 32'(busy), 0, "ignored request never started");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule